// File: doc/BRIEF.md
# Wait-State Memory Access Sequencer

This block times memory accesses for a signal-processing core that reaches four address spaces: X data, Y data, program and I/O. For each request, an external address-range compare reports whether the target space is internal or external. Every space has its own programmable external wait-state count. The block accepts one request at a time. It holds the core with a stall for the extra cycles the access needs and then pulses a completion strobe.

A request names one space or asks for a paired X/Y access. A paired access is free when both halves are internal. When exactly one half is external, it costs only that half's wait states. When both halves go external, they share a single external bus: the X half runs first and the Y half second, each in its own window. Together they cost two overhead cycles plus both wait counts. While the stall is high, the block reports which space owns the bus.

Top module: `ws_mem_seq`

## Requirements
- R1: An access whose target is internal (`ext_map` bit for that space is 0; space codes are 0=X, 1=Y, 2=P, 3=IO) adds no cycles. `stall` stays low and `done` pulses in the cycle after acceptance.
- R2: A single external access adds exactly that space's wait count. The counts are written through `cfg_wdata` with X in bits [3:0], Y in [7:4], P in [11:8] and IO in [15:12]. `stall` is high for that many cycles starting the cycle after acceptance.
- R3: A paired access (`req_pair`=1, `req_space` ignored) with X internal and Y external stalls for exactly the Y count.
- R4: A paired access with X external and Y internal stalls for exactly the X count.
- R5: A paired access with both halves external stalls for exactly 2 + X count + Y count.
- R6: In a paired access with both halves external, `bus_space` reads 0 (X) for the first 1 + X count stall cycles. It then reads 1 (Y) for the remaining 1 + Y count cycles, and `bus_strobe` is high in every stall cycle.
- R7: `req_ready` is low whenever `stall` is high. A request presented during a stall is neither accepted nor later serviced.
- R8: A configuration write (`cfg_we`) presented while `stall` is high is ignored. One presented while `stall` is low takes effect for requests accepted afterwards.
- R9: `done` is a one-cycle pulse. It rises in the cycle after the last stall cycle and is never high together with `stall`.
- R10: After reset, `stall` and `done` are low, `req_ready` is high and all four wait counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Wait-count register write enable |
| cfg_wdata | input | 16 | Four 4-bit wait counts, X lowest |
| req_valid | input | 1 | Access request |
| req_space | input | 2 | Target space of a single access |
| req_pair | input | 1 | Paired X/Y access |
| ext_map | input | 4 | Per-space external flag from range compare |
| req_ready | output | 1 | Block can accept a request |
| stall | output | 1 | Hold the core for an extra cycle |
| done | output | 1 | Access complete pulse |
| bus_strobe | output | 1 | External bus window active |
| bus_space | output | 2 | Space owning the external bus |

## Verification
The assertions assume that requests and configuration writes arrive as synchronous, single-cycle-sampled inputs. They also assume that `ext_map` is stable whenever a request is accepted. The bench keeps to this by changing every input on the falling edge, and it only raises `req_valid` once `req_ready` and `done` are settled. The bench sweeps four wait-count sets, each with the four spaces internal and external plus all four pair mappings. Stray requests and configuration writes are injected in the middle of stalls.

// File: rtl/ws_seq_pkg.sv
package ws_seq_pkg;
   typedef enum logic [1:0] {
      SP_X  = 2'd0,
      SP_Y  = 2'd1,
      SP_P  = 2'd2,
      SP_IO = 2'd3
   } space_e;

   localparam int NUM_SPACES = 4;
   localparam int PAIR_OVERHEAD = 2;
endpackage

// File: rtl/ws_cfg_regs.sv
module ws_cfg_regs #(
   parameter int WW = 4,
   parameter int NS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            busy,
   input  logic [NS*WW-1:0] wr_data,
   output logic [NS*WW-1:0] waits
);
   // one field register per space; writes are refused mid-access
   for (genvar k = 0; k < NS; k++) begin : g_field
      logic [WW-1:0] field_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            field_q <= '0;
         else if (wr_en && !busy)
            field_q <= wr_data[k*WW +: WW];
      end
      assign waits[k*WW +: WW] = field_q;
   end
endmodule

// File: rtl/ws_cost_calc.sv
module ws_cost_calc
   import ws_seq_pkg::*;
#(
   parameter int WW = 4,
   parameter int NS = 4,
   localparam int CW = WW + 2
) (
   input  logic [NS*WW-1:0] waits,
   input  logic [1:0]       space,
   input  logic             pair,
   input  logic [NS-1:0]    ext_map,
   output logic [CW-1:0]    total,
   output logic [CW-1:0]    first_len,
   output logic [1:0]       first_sp
);
   logic [WW-1:0] wx, wy, wsel;

   assign wx   = waits[0 +: WW];
   assign wy   = waits[WW +: WW];
   assign wsel = waits[space*WW +: WW];

   always_comb begin
      total     = '0;
      first_len = '0;
      first_sp  = space;
      if (pair) begin
         first_sp = SP_X;
         unique case (ext_map[1:0])
            2'b01: begin
               total     = CW'(wx);
               first_len = CW'(wx);
            end
            2'b10: begin
               total     = CW'(wy);
               first_len = CW'(wy);
               first_sp  = SP_Y;
            end
            2'b11: begin
               total     = CW'(PAIR_OVERHEAD) + CW'(wx) + CW'(wy);
               first_len = CW'(1) + CW'(wx);
            end
            default: ;
         endcase
      end else if (ext_map[space]) begin
         total     = CW'(wsel);
         first_len = CW'(wsel);
      end
   end
endmodule

// File: rtl/ws_seq_fsm.sv
module ws_seq_fsm
   import ws_seq_pkg::*;
#(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [CW-1:0] total,
   input  logic [CW-1:0] first_len,
   input  logic [1:0]    first_sp,
   output logic          stall,
   output logic          done,
   output logic [1:0]    bus_space
);
   logic [CW-1:0] rem_q, pos_q, flen_q;
   logic [1:0]    fsp_q;
   logic          done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         pos_q  <= '0;
         flen_q <= '0;
         fsp_q  <= SP_X;
         done_q <= 1'b0;
      end else if (accept) begin
         rem_q  <= total;
         pos_q  <= '0;
         flen_q <= first_len;
         fsp_q  <= first_sp;
         done_q <= (total == '0);
      end else if (rem_q != '0) begin
         rem_q  <= rem_q - 1'b1;
         pos_q  <= pos_q + 1'b1;
         done_q <= (rem_q == CW'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign stall     = (rem_q != '0);
   assign done      = done_q;
   assign bus_space = (pos_q < flen_q) ? fsp_q : SP_Y;
endmodule

// File: rtl/ws_mem_seq.sv
module ws_mem_seq
   import ws_seq_pkg::*;
#(
   parameter int WW = 4,
   localparam int NS = NUM_SPACES,
   localparam int CW = WW + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [NS*WW-1:0] cfg_wdata,
   input  logic             req_valid,
   input  logic [1:0]       req_space,
   input  logic             req_pair,
   input  logic [NS-1:0]    ext_map,
   output logic             req_ready,
   output logic             stall,
   output logic             done,
   output logic             bus_strobe,
   output logic [1:0]       bus_space
);
   if (WW < 1 || WW > 8) begin : g_bad_width
      $error("ws_mem_seq: WW must lie in 1..8");
   end

   logic [NS*WW-1:0] waits;
   logic [CW-1:0]    total, first_len;
   logic [1:0]       first_sp;
   logic             accept;

   ws_cfg_regs #(.WW(WW), .NS(NS)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .busy    (stall),
      .wr_data (cfg_wdata),
      .waits   (waits)
   );

   ws_cost_calc #(.WW(WW), .NS(NS)) u_cost (
      .waits     (waits),
      .space     (req_space),
      .pair      (req_pair),
      .ext_map   (ext_map),
      .total     (total),
      .first_len (first_len),
      .first_sp  (first_sp)
   );

   assign req_ready = !stall;
   assign accept    = req_valid && req_ready;

   ws_seq_fsm #(.CW(CW)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .total     (total),
      .first_len (first_len),
      .first_sp  (first_sp),
      .stall     (stall),
      .done      (done),
      .bus_space (bus_space)
   );

   assign bus_strobe = stall;
endmodule

// File: rtl/ws_seq_chk.sv
module ws_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       req_ready,
   input logic       stall,
   input logic       done,
   input logic       bus_strobe,
   input logic [1:0] bus_space
);
   p_ready_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !req_ready);

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stall) |-> done);

   p_done_not_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !stall);

   p_free_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(stall)) |-> $past(req_valid && req_ready));

   p_y_after_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && $past(stall) && $past(bus_space) == 2'd1) |-> bus_space == 2'd1);

   p_strobe_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe |-> !done);
endmodule

bind ws_mem_seq ws_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .stall      (stall),
   .done       (done),
   .bus_strobe (bus_strobe),
   .bus_space  (bus_space)
);

// File: tb/ws_mem_seq_test.sv
module ws_mem_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [15:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_space = '0;
   logic        req_pair = 1'b0;
   logic [3:0]  ext_map = '0;
   logic        req_ready, stall, done, bus_strobe;
   logic [1:0]  bus_space;

   int checks = 0;
   int errors = 0;
   int w [4];

   always #4 clk = ~clk;

   ws_mem_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_space(req_space), .req_pair(req_pair),
      .ext_map(ext_map), .req_ready(req_ready), .stall(stall), .done(done),
      .bus_strobe(bus_strobe), .bus_space(bus_space)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic program_waits(input int a, input int b, input int c, input int d);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = {4'(d), 4'(c), 4'(b), 4'(a)};
      @(negedge clk);
      cfg_we = 1'b0;
      w[0] = a; w[1] = b; w[2] = c; w[3] = d;
   endtask

   // inj: 0 none, 1 stray request mid-stall, 2 config write mid-stall
   task automatic access(input logic [1:0] sp, input bit pair, input logic [3:0] em,
                         input int exp_n, input int exp_x, input string req, input int inj);
      int n, nx, guard;
      bit injected, got_done, bad_ready, bad_strobe;
      n = 0; nx = 0; injected = 0; got_done = 0; bad_ready = 0; bad_strobe = 0;
      @(negedge clk);
      req_valid = 1'b1; req_space = sp; req_pair = pair; ext_map = em;
      @(negedge clk);
      req_valid = 1'b0;
      for (guard = 0; guard < 64; guard++) begin
         if (done) begin got_done = 1; break; end
         if (stall) begin
            n++;
            if (bus_space == 2'd0) nx++;
            if (req_ready) bad_ready = 1;
            if (!bus_strobe) bad_strobe = 1;
            if (!injected && inj == 1) begin
               req_valid = 1'b1; req_space = 2'd3; req_pair = 1'b0; ext_map = 4'hF;
               injected = 1;
            end else if (!injected && inj == 2) begin
               cfg_we = 1'b1; cfg_wdata = 16'hFFFF; injected = 1;
            end
         end
         @(negedge clk);
         req_valid = 1'b0; cfg_we = 1'b0;
      end
      check(got_done, {req, " done seen"}, got_done, 1);
      check(n == exp_n, {req, " stall cycles"}, n, exp_n);
      check(!bad_ready, "R7 ready low in stall", bad_ready, 0);
      check(!bad_strobe, "R6 strobe in stall", bad_strobe, 0);
      if (exp_x >= 0) check(nx == exp_x, "R6 X window cycles", nx, exp_x);
      @(negedge clk);
      check(!done, "R9 done single pulse", done, 0);
      if (inj == 1) begin
         @(negedge clk);
         check(!stall && !done, "R7 stray request ignored", stall, 0);
      end
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int wxs [4];
      int wys [4];
      int wps [4];
      int wis [4];
      wxs = '{0, 1, 7, 15}; wys = '{15, 0, 2, 9};
      wps = '{3, 15, 0, 1};  wis = '{0, 6, 15, 4};
      w = '{0, 0, 0, 0};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check(!stall && !done && req_ready, "R10 reset outputs", stall, 0);
      access(2'd0, 1'b0, 4'hF, 0, -1, "R10 zero waits after reset", 0);

      for (int c = 0; c < 4; c++) begin
         program_waits(wxs[c], wys[c], wps[c], wis[c]);
         for (int s = 0; s < 4; s++) begin
            access(2'(s), 1'b0, 4'h0, 0, -1, "R1 internal single", 0);
            access(2'(s), 1'b0, 4'(1 << s), w[s], -1, "R2 external single", 0);
         end
         access(2'd2, 1'b1, 4'b0000, 0, -1, "R1 pair both internal", 0);
         access(2'd2, 1'b1, 4'b0010, w[1], 0, "R3 pair Y external", 0);
         access(2'd3, 1'b1, 4'b0001, w[0], w[0], "R4 pair X external", 0);
         access(2'd0, 1'b1, 4'b0011, 2 + w[0] + w[1], 1 + w[0], "R5 pair both external", 0);
      end

      // R7: stray request during a stall
      program_waits(5, 3, 2, 1);
      access(2'd0, 1'b1, 4'b0011, 10, 6, "R7 stall with stray request", 1);
      // R8: config write during a stall is dropped
      access(2'd2, 1'b0, 4'b0100, 2, -1, "R8 stall with config write", 2);
      access(2'd0, 1'b0, 4'b0001, 5, -1, "R8 X count unchanged", 0);
      access(2'd3, 1'b0, 4'b1000, 1, -1, "R8 IO count unchanged", 0);
      // R8: write while idle takes effect
      program_waits(9, 4, 2, 1);
      access(2'd0, 1'b0, 4'b0001, 9, -1, "R8 idle write applied", 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule